// File: doc/BRIEF.md
# Warp Lane Shuffle Crossbar

This block moves one data word between the lanes of a warp in a single operation. Every lane asks for a source lane. The block works out that source from a mode, an operand and a segment width, then sends the word from the source lane to the lane that asked. Four ways of choosing the source share one crossbar:

- an absolute index;
- a delta toward lower lane IDs;
- a delta toward higher lane IDs;
- an XOR pattern applied to the lane ID.

The segment width cuts the warp into aligned groups. No value crosses from one group into another.

An execution pipeline drives one request per cycle with `in_valid`. The request holds the data of every lane, an active mask, the mode and the operands. The result vector is registered and appears one cycle later with `out_valid`. A small two-state controller tracks the output strobe. State IDLE moves to EMIT on a valid request (transition LOAD). EMIT stays in EMIT on another request (transition REFILL). EMIT returns to IDLE when no request arrives (transition DRAIN). While the block is idle, the output data holds its last value.

Top module: `warp_xbar`

## Requirements
- R1: `out_valid` rises exactly one cycle after a cycle with `in_valid` high, and is low after a cycle with `in_valid` low. While `in_valid` is low, `out_data` keeps its previous value.
- R2: While `rst_n` is low, `out_valid` is 0 and `out_data` is all zeros.
- R3: Mode code 0 (index) gives lane i the word of lane `base + (op mod w)`. Here w is the segment width, base is `i` rounded down to a multiple of w, and the operand is the lane's field of `in_opnd`.
- R4: Mode code 1 (up) gives lane i the word of lane `i - op` when `(i mod w) >= op`. Otherwise lane i gets its own word.
- R5: Mode code 2 (down) gives lane i the word of lane `i + op` when `(i mod w) + op < w`. Otherwise lane i gets its own word.
- R6: Mode code 3 (xor) gives lane i the word of lane `i XOR (op mod w)`. Operand bits at or above the width are ignored.
- R7: `in_seg_lg` selects a segment width of 2^`in_seg_lg` lanes for codes 0 to 5. Codes 6 and 7 act exactly as code 5 (the whole warp).
- R8: An active lane whose computed source lane is inactive receives its own input word.
- R9: An inactive lane (its `in_active` bit is 0) outputs its own input word, whatever the mode.
- R10: With `in_uniform` high, the operand field of lane 0 is used by every lane, and the fields of the other lanes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | 0 index, 1 up, 2 down, 3 xor |
| in_uniform | input | 1 | Use lane 0's operand for all lanes |
| in_seg_lg | input | 3 | log2 of the segment width |
| in_active | input | 32 | Active mask, bit i for lane i |
| in_opnd | input | 160 | Per-lane operand, 5 bits per lane, lane i at [5i+4:5i] |
| in_data | input | 1024 | Per-lane word, lane i at [32i+31:32i] |
| out_valid | output | 1 | Result strobe |
| out_data | output | 1024 | Per-lane result, same packing as `in_data` |

## Verification
Each lane carries a distinct word that encodes its index, so a wrong source lane always shows up as a mismatched value.

The data patterns are tried against the following cases, and each case separates specific wrong behaviours:
- **Every mode at several segment widths.** An up or down delta that crosses a segment edge must fall back to the lane's own word. This is the case that separates clamping from wrapping.
- **Width 1 and width codes above 5.** These expose any off-by-one in the width mask.
- **XOR operands with bits above the width.** These show whether high operand bits leak across segments.
- **Sparse active masks.** These separate an inactive caller from an inactive source.
- **Per-lane operands whose lane-0 field differs from the rest.** These reveal whether the uniform selection is honoured.

// File: rtl/warp_xbar_pkg.sv
package warp_xbar_pkg;
    typedef enum logic [1:0] {
        SHF_IDX  = 2'd0,
        SHF_UP   = 2'd1,
        SHF_DOWN = 2'd2,
        SHF_XOR  = 2'd3
    } shf_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } xbar_state_e;
endpackage

// File: rtl/lane_src_calc.sv
module lane_src_calc
    import warp_xbar_pkg::*;
#(
    parameter int LANES = 32,
    parameter int LANE  = 0,
    localparam int LW   = $clog2(LANES)
) (
    input  shf_mode_e          mode,
    input  logic [LW-1:0]      op,
    input  logic [LW-1:0]      seg_mask,
    input  logic [LW:0]        seg_w,
    output logic [LW-1:0]      src,
    output logic               keep_own
);
    localparam logic [LW-1:0] ME = LW'(LANE);

    logic [LW-1:0] rel;
    logic [LW-1:0] base;
    logic [LW:0]   reach;

    always_comb begin
        rel      = ME & seg_mask;
        base     = ME & ~seg_mask;
        reach    = {1'b0, rel} + {1'b0, op};
        src      = ME;
        keep_own = 1'b0;
        unique case (mode)
            SHF_IDX:  src = base | (op & seg_mask);
            SHF_UP: begin
                if (rel >= op) src = ME - op;
                else           keep_own = 1'b1;
            end
            SHF_DOWN: begin
                if (reach < seg_w) src = ME + op;
                else               keep_own = 1'b1;
            end
            SHF_XOR:  src = ME ^ (op & seg_mask);
        endcase
    end
endmodule

// File: rtl/xbar_sel.sv
module xbar_sel #(
    parameter int LANES = 32,
    parameter int DW    = 32,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [LANES*DW-1:0] data,
    input  logic [LANES-1:0]    active,
    input  logic [LANES*LW-1:0] src,
    input  logic [LANES-1:0]    keep_own,
    output logic [LANES*DW-1:0] result
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] s;
        assign s = src[g*LW +: LW];
        always_comb begin
            if (!active[g] || keep_own[g] || !active[s])
                result[g*DW +: DW] = data[g*DW +: DW];
            else
                result[g*DW +: DW] = data[s*DW +: DW];
        end
    end
endmodule

// File: rtl/warp_xbar.sv
module warp_xbar
    import warp_xbar_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 32,
    localparam int LW   = $clog2(LANES),
    localparam int GW   = $clog2(LW + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          in_mode,
    input  logic                in_uniform,
    input  logic [GW-1:0]       in_seg_lg,
    input  logic [LANES-1:0]    in_active,
    input  logic [LANES*LW-1:0] in_opnd,
    input  logic [LANES*DW-1:0] in_data,
    output logic                out_valid,
    output logic [LANES*DW-1:0] out_data
);
    xbar_state_e   state, state_nx;
    logic [GW-1:0] lg_eff;
    logic [LW:0]   seg_w;
    logic [LW-1:0] seg_mask;
    logic [LANES*LW-1:0] src_all;
    logic [LANES-1:0]    own_all;
    logic [LANES*DW-1:0] result;

    always_comb begin
        lg_eff   = (in_seg_lg > GW'(LW)) ? GW'(LW) : in_seg_lg;
        seg_w    = (LW+1)'(1) << lg_eff;
        seg_mask = LW'(seg_w - (LW+1)'(1));
    end

    for (genvar g = 0; g < LANES; g++) begin : g_src
        logic [LW-1:0] op_g;
        assign op_g = in_uniform ? in_opnd[LW-1:0] : in_opnd[g*LW +: LW];
        lane_src_calc #(.LANES(LANES), .LANE(g)) u_calc (
            .mode     (shf_mode_e'(in_mode)),
            .op       (op_g),
            .seg_mask (seg_mask),
            .seg_w    (seg_w),
            .src      (src_all[g*LW +: LW]),
            .keep_own (own_all[g])
        );
    end

    xbar_sel #(.LANES(LANES), .DW(DW)) u_sel (
        .data     (in_data),
        .active   (in_active),
        .src      (src_all),
        .keep_own (own_all),
        .result   (result)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid)  state_nx = ST_EMIT;
            ST_EMIT: if (!in_valid) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_data <= '0;
        else if (in_valid) out_data <= result;
    end

    assign out_valid = (state == ST_EMIT);
endmodule

// File: rtl/warp_xbar_chk.sv
module warp_xbar_chk #(
    parameter int LANES = 32,
    parameter int DW    = 32,
    localparam int LW   = $clog2(LANES),
    localparam int GW   = $clog2(LW + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [1:0]          in_mode,
    input logic                in_uniform,
    input logic [GW-1:0]       in_seg_lg,
    input logic [LANES-1:0]    in_active,
    input logic [LANES*LW-1:0] in_opnd,
    input logic [LANES*DW-1:0] in_data,
    input logic                out_valid,
    input logic [LANES*DW-1:0] out_data
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data)); // R1
    AST_UP_ZERO_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_uniform && in_mode == 2'd1 && in_opnd[LW-1:0] == '0)
        |=> out_data == $past(in_data)); // R4

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        AST_INACTIVE_SELF: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_active[g])
            |=> out_data[g*DW +: DW] == $past(in_data[g*DW +: DW])); // R9
    end
endmodule

bind warp_xbar warp_xbar_chk #(.LANES(LANES), .DW(DW)) u_chk (.*);

// File: tb/sim_warp_xbar.sv
module sim_warp_xbar;
    localparam int LANES = 32;
    localparam int DW    = 32;
    localparam int LW    = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [1:0]          in_mode = '0;
    logic                in_uniform = 1'b0;
    logic [2:0]          in_seg_lg = '0;
    logic [LANES-1:0]    in_active = '0;
    logic [LANES*LW-1:0] in_opnd = '0;
    logic [LANES*DW-1:0] in_data = '0;
    logic                out_valid;
    logic [LANES*DW-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    warp_xbar u0 (.*);

    // {mode[42:41], uniform[40], seg_lg[39:37], op[36:32], active[31:0]}
    localparam logic [42:0] VECS [12] = '{
        {2'd0, 1'b1, 3'd5, 5'd5,  32'hFFFF_FFFF},
        {2'd0, 1'b0, 3'd2, 5'd3,  32'hFFFF_FFFF},
        {2'd1, 1'b1, 3'd5, 5'd3,  32'hFFFF_FFFF},
        {2'd1, 1'b1, 3'd3, 5'd1,  32'hAAAA_5555},
        {2'd2, 1'b1, 3'd4, 5'd2,  32'hF0F0_FF0F},
        {2'd2, 1'b0, 3'd3, 5'd6,  32'hFFFF_FFFF},
        {2'd3, 1'b1, 3'd5, 5'd1,  32'hFFFF_FFFF},
        {2'd3, 1'b1, 3'd2, 5'd31, 32'hFFFF_FFFF},
        {2'd0, 1'b1, 3'd0, 5'd7,  32'hFFFF_FFFF},
        {2'd2, 1'b1, 3'd7, 5'd4,  32'hFFFF_FFFF},
        {2'd3, 1'b0, 3'd4, 5'd9,  32'h0F0F_3C3C},
        {2'd1, 1'b0, 3'd6, 5'd11, 32'hFFFF_0000}
    };

    function automatic logic [DW-1:0] word(int i, int seed);
        return {8'(seed), 8'(i), 8'(~i), 8'(seed + 3 * i)};
    endfunction

    function automatic int lane_op(int i, int opu);
        return (i * 7 + opu) % 32;
    endfunction

    function automatic int src_of(int i, int md, int lg, int op);
        int w, m, rel, base;
        if (lg > 5) lg = 5;
        w = 1 << lg;
        m = w - 1;
        rel = i & m;
        base = i & ~m;
        case (md)
            0: return base | (op & m);
            1: return (rel >= op) ? i - op : i;
            2: return (rel + op < w) ? i + op : i;
            default: return i ^ (op & m);
        endcase
    endfunction

    function automatic logic [DW-1:0] expect_lane(int i, int md, int uni, int lg,
                                                  int opu, logic [31:0] act, int seed);
        int op, s;
        op = uni != 0 ? opu : lane_op(i, opu);
        s = src_of(i, md, lg, op);
        if (!act[i] || !act[s]) return word(i, seed);
        return word(s, seed);
    endfunction

    task automatic chk(bit ok, string req, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic drive(int md, int uni, int lg, int opu, logic [31:0] act, int seed);
        @(negedge clk);
        in_valid = 1'b1;
        in_mode = 2'(md);
        in_uniform = uni[0];
        in_seg_lg = 3'(lg);
        in_active = act;
        for (int i = 0; i < LANES; i++) begin
            in_data[i*DW +: DW] = word(i, seed);
            in_opnd[i*LW +: LW] = 5'(lane_op(i, opu));
        end
    endtask

    task automatic check_all(string req, int md, int uni, int lg, int opu,
                             logic [31:0] act, int seed);
        int bad = 0;
        logic [DW-1:0] eg = '0, gg = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [DW-1:0] e;
            e = expect_lane(i, md, uni, lg, opu, act, seed);
            if (out_data[i*DW +: DW] !== e && bad == 0) begin
                eg = e;
                gg = out_data[i*DW +: DW];
                bad = 1;
            end
        end
        chk(bad == 0, req, gg, eg);
    endtask

    initial begin
        while (cyc < 20000) @(posedge clk) cyc++;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog got=%0d exp=done", cyc);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        string tags [4] = '{"R3", "R4", "R5", "R6"};
        // R2: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R2 valid", 32'(out_valid), 32'd0);
        chk(out_data == '0, "R2 data", out_data[31:0], 32'd0);
        rst_n = 1'b1;

        // Table walk
        for (int v = 0; v < 12; v++) begin
            int md, uni, lg, opu;
            logic [31:0] act;
            md = int'(VECS[v][42:41]);
            uni = int'(VECS[v][40]);
            lg = int'(VECS[v][39:37]);
            opu = int'(VECS[v][36:32]);
            act = VECS[v][31:0];
            drive(md, uni, lg, opu, act, v + 1);
            @(negedge clk);
            in_valid = 1'b0;
            chk(out_valid == 1'b1, "R1 strobe", 32'(out_valid), 32'd1);
            check_all(tags[md], md, uni, lg, opu, act, v + 1);
        end

        // R1: idle hold and strobe drop
        begin
            logic [LANES*DW-1:0] snap;
            snap = out_data;
            in_data = '1;
            @(negedge clk);
            chk(out_valid == 1'b0, "R1 drop", 32'(out_valid), 32'd0);
            chk(out_data == snap, "R1 hold", out_data[31:0], snap[31:0]);
        end

        // R7: width code 7 equals whole warp, down by 20
        drive(2, 1, 7, 20, 32'hFFFF_FFFF, 40);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_data[5*DW +: DW] == word(25, 40), "R7 code7", out_data[5*DW +: DW], word(25, 40));
        check_all("R7", 2, 1, 5, 20, 32'hFFFF_FFFF, 40);

        // R8: inactive source gives own word (lane 4 reads lane 3, which is off)
        drive(1, 1, 5, 1, 32'hFFFF_FFF7, 41);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_data[4*DW +: DW] == word(4, 41), "R8 src off", out_data[4*DW +: DW], word(4, 41));
        chk(out_data[5*DW +: DW] == word(4, 41), "R8 src on", out_data[5*DW +: DW], word(4, 41));

        // R9: inactive caller keeps own word (lane 0 off, xor 1)
        drive(3, 1, 5, 1, 32'hFFFF_FFFE, 42);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_data[0 +: DW] == word(0, 42), "R9 caller off", out_data[0 +: DW], word(0, 42));

        // R10: uniform uses lane 0 operand (lane 0 field = 9, lane 31 field differs)
        drive(0, 1, 5, 9, 32'hFFFF_FFFF, 43);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_data[31*DW +: DW] == word(9, 43), "R10 uniform", out_data[31*DW +: DW], word(9, 43));

        // R1: back-to-back requests
        drive(3, 1, 5, 2, 32'hFFFF_FFFF, 44);
        drive(3, 1, 5, 4, 32'hFFFF_FFFF, 45);
        chk(out_data[0 +: DW] == word(2, 44), "R1 first", out_data[0 +: DW], word(2, 44));
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R1 second strobe", 32'(out_valid), 32'd1);
        chk(out_data[0 +: DW] == word(4, 45), "R1 second", out_data[0 +: DW], word(4, 45));

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule